// File: doc/BRIEF.md
# Temperature Limit Alarm with Hysteresis

This block watches a stream of signed temperature samples and raises an alarm when a sample goes outside a programmable window. Software sets three values through a small indexed register port: an upper limit, a lower limit and a hysteresis amount in whole degrees. Each sample is a 16-bit two's-complement number in which one LSB is 1/128 degree. A sample above the upper limit sets an over-temperature flag. A sample below the lower limit sets an under-temperature flag. The alarm output is high while either flag is set.

The hysteresis is scaled to sample units by multiplying it by 128. A flag does not clear as soon as the sample comes back inside the window. The over flag clears only when a sample drops below the upper limit minus the scaled hysteresis. The under flag clears only when a sample rises above the lower limit plus the scaled hysteresis. A sample between a limit and its release threshold leaves that flag as it is. Flags change only on a valid sample and never on a register write. The release thresholds use a wider signed width, so they cannot wrap even when a limit is programmed at the edge of the 16-bit range.

Top module: `thermal_limit_alarm`

## Requirements
- R1: After reset, index 5 reads 0x0005, index 6 reads 0x2000 and index 7 reads 0x0500, and overFlag, underFlag and alarmOut are all 0.
- R2: Index 5 (hysteresis) keeps only bits [3:0] of a write. Read-data bits [15:4] are always 0 when index 5 is selected.
- R3: Reading any index other than 5, 6 or 7 returns 0x0000. Reads are combinational from regAddr.
- R4: On the clock edge where sampleValid is high, overFlag is set if the sample is strictly greater than the upper limit (index 6). A sample equal to the limit does not set it.
- R5: On the clock edge where sampleValid is high, underFlag is set if the sample is strictly less than the lower limit (index 7). A sample equal to the limit does not set it.
- R6: A set overFlag clears on a valid sample strictly less than upper limit minus hysteresis×128. A sample from that threshold up to the upper limit leaves the flag unchanged.
- R7: A set underFlag clears on a valid sample strictly greater than lower limit plus hysteresis×128. A sample from the lower limit up to that threshold leaves the flag unchanged.
- R8: alarmOut is high exactly when overFlag or underFlag is high.
- R9: All comparisons treat the samples and the limits as two's complement.
- R10: The release thresholds are computed in 18-bit signed arithmetic and do not wrap. With upper limit 0x8000 and hysteresis 15, overFlag never clears. With lower limit 0x7FFF and hysteresis 15, underFlag never clears.
- R11: Flags are evaluated only on a valid sample. A register write or an idle cycle leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe: sampleTemp holds a new sample |
| sampleTemp | input | 16 | Signed temperature sample, 1/128 degree per LSB |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register index for reads and writes |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| alarmOut | output | 1 | Active-high alarm, OR of the two flags |
| overFlag | output | 1 | Over-temperature status |
| underFlag | output | 1 | Under-temperature status |

## Verification
A wrong flag state shows on overFlag, underFlag and alarmOut one clock edge after the sample that caused it, and stays wrong until a later sample forces the flag one way or the other. The tests therefore place samples exactly on each limit and each release threshold, one LSB on either side, so that an off-by-one, an unsigned compare or a truncated threshold changes a flag that should have held. A bad setpoint register shows at once on regRdData, and it also shows in the next flag decision that uses that setpoint. The write-only and idle-cycle tests look at the flags after a write, to confirm that no stray evaluation took place.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_HYST = 2'd1,
    RD_HIGH = 2'd2,
    RD_LOW  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrHyst;
    logic   wrHigh;
    logic   wrLow;
    logic   evalSample;
    rdSel_e rdSel;
  } alarmStrobe_t;

endpackage

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int HYST_IDX = 5,
  parameter int HIGH_IDX = 6,
  parameter int LOW_IDX  = 7
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sampleValid,
  output alarmStrobe_t      strobes
);

  localparam logic [ADDR_W-1:0] HYST_A = ADDR_W'(HYST_IDX);
  localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(HIGH_IDX);
  localparam logic [ADDR_W-1:0] LOW_A  = ADDR_W'(LOW_IDX);

  logic hitHyst, hitHigh, hitLow;

  always_comb begin
    hitHyst = (regAddr == HYST_A);
    hitHigh = (regAddr == HIGH_A);
    hitLow  = (regAddr == LOW_A);

    strobes            = '0;
    strobes.wrHyst     = regWrEn && hitHyst;
    strobes.wrHigh     = regWrEn && hitHigh;
    strobes.wrLow      = regWrEn && hitLow;
    strobes.evalSample = sampleValid;

    if (hitHyst)      strobes.rdSel = RD_HYST;
    else if (hitHigh) strobes.rdSel = RD_HIGH;
    else if (hitLow)  strobes.rdSel = RD_LOW;
    else              strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/thermal_alarm_dp.sv
module thermal_alarm_dp
  import thermal_alarm_pkg::*;
#(
  parameter int              TEMP_W    = 16,
  parameter int              HYST_W    = 4,
  parameter int              FRAC_BITS = 7,
  parameter logic [15:0]     HIGH_RST  = 16'h2000,
  parameter logic [15:0]     LOW_RST   = 16'h0500,
  parameter logic [3:0]      HYST_RST  = 4'd5
) (
  input  logic              clk,
  input  logic              rstN,
  input  alarmStrobe_t      strobes,
  input  logic [TEMP_W-1:0] wrData,
  input  logic [TEMP_W-1:0] sampleTemp,
  output logic [TEMP_W-1:0] rdData,
  output logic              overFlag,
  output logic              underFlag
);

  localparam int SIGN_PAD = 2;
  localparam int EXT_W    = TEMP_W + SIGN_PAD;
  localparam int ZPAD_W   = EXT_W - HYST_W - FRAC_BITS;

  logic signed [TEMP_W-1:0] highLim, lowLim;
  logic        [HYST_W-1:0] hystVal;

  logic signed [EXT_W-1:0] hystScaled, highExt, lowExt, sampleExt;
  logic signed [EXT_W-1:0] relHigh, relLow;
  logic aboveHigh, belowLow, belowRelHigh, aboveRelLow;

  // setpoint storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highLim <= HIGH_RST[TEMP_W-1:0];
      lowLim  <= LOW_RST[TEMP_W-1:0];
      hystVal <= HYST_RST[HYST_W-1:0];
    end else begin
      if (strobes.wrHigh) highLim <= wrData;
      if (strobes.wrLow)  lowLim  <= wrData;
      if (strobes.wrHyst) hystVal <= wrData[HYST_W-1:0];
    end
  end

  // widened thresholds, no wrap
  always_comb begin
    hystScaled = signed'({{ZPAD_W{1'b0}}, hystVal, {FRAC_BITS{1'b0}}});
    highExt    = {{SIGN_PAD{highLim[TEMP_W-1]}}, highLim};
    lowExt     = {{SIGN_PAD{lowLim[TEMP_W-1]}}, lowLim};
    sampleExt  = {{SIGN_PAD{sampleTemp[TEMP_W-1]}}, sampleTemp};
    relHigh    = highExt - hystScaled;
    relLow     = lowExt + hystScaled;

    aboveHigh    = sampleExt > highExt;
    belowLow     = sampleExt < lowExt;
    belowRelHigh = sampleExt < relHigh;
    aboveRelLow  = sampleExt > relLow;
  end

  // flag state, evaluated only on a sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overFlag  <= 1'b0;
      underFlag <= 1'b0;
    end else if (strobes.evalSample) begin
      if (aboveHigh)         overFlag <= 1'b1;
      else if (belowRelHigh) overFlag <= 1'b0;
      if (belowLow)          underFlag <= 1'b1;
      else if (aboveRelLow)  underFlag <= 1'b0;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_HYST: rdData = {{(TEMP_W-HYST_W){1'b0}}, hystVal};
      RD_HIGH: rdData = highLim;
      RD_LOW:  rdData = lowLim;
      default: rdData = '0;
    endcase
  end

  p_over_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalSample && (signed'(sampleTemp) > highLim)) |=> overFlag);

  p_under_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalSample && (signed'(sampleTemp) < lowLim)) |=> underFlag);

  p_over_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalSample && !aboveHigh && !belowRelHigh) |=> $stable(overFlag));

  p_under_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalSample && !belowLow && !aboveRelLow) |=> $stable(underFlag));

  p_no_eval_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evalSample |=> ($stable(overFlag) && $stable(underFlag)));

  p_release_order_r10: assert property (@(posedge clk) disable iff (!rstN)
    (relHigh <= highExt) && (relLow >= lowExt));

endmodule

// File: rtl/thermal_limit_alarm.sv
module thermal_limit_alarm
  import thermal_alarm_pkg::*;
#(
  parameter int TEMP_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int HYST_W    = 4,
  parameter int FRAC_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TEMP_W-1:0] regWrData,
  output logic [TEMP_W-1:0] regRdData,
  output logic              alarmOut,
  output logic              overFlag,
  output logic              underFlag
);

  localparam int HYST_IDX = 5;
  localparam int HIGH_IDX = 6;
  localparam int LOW_IDX  = 7;

  alarmStrobe_t strobes;

  thermal_alarm_ctrl #(
    .ADDR_W(ADDR_W), .HYST_IDX(HYST_IDX), .HIGH_IDX(HIGH_IDX), .LOW_IDX(LOW_IDX)
  ) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .sampleValid(sampleValid), .strobes(strobes)
  );

  thermal_alarm_dp #(
    .TEMP_W(TEMP_W), .HYST_W(HYST_W), .FRAC_BITS(FRAC_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .sampleTemp(sampleTemp), .rdData(regRdData),
    .overFlag(overFlag), .underFlag(underFlag)
  );

  assign alarmOut = overFlag | underFlag;

  p_hyst_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(HYST_IDX)) |-> (regRdData[TEMP_W-1:HYST_W] == '0));

  p_unused_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < ADDR_W'(HYST_IDX)) |-> (regRdData == '0));

endmodule

// File: tb/thermal_limit_alarm_tb.sv
module thermal_limit_alarm_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleTemp = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        alarmOut, overFlag, underFlag;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_limit_alarm u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .alarmOut(alarmOut), .overFlag(overFlag), .underFlag(underFlag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // flags packed as {alarm, over, under}
  task automatic checkFlags(input string req, input logic ov, input logic un);
    check(req, {13'd0, alarmOut, overFlag, underFlag}, {13'd0, ov | un, ov, un});
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic applySample(input logic [15:0] t);
    @(negedge clk);
    sampleValid = 1'b1; sampleTemp = t;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic testReset();
    checkFlags("R1 flags", 1'b0, 1'b0);
    readCheck("R1 hyst", 3'd5, 16'h0005);
    readCheck("R1 high", 3'd6, 16'h2000);
    readCheck("R1 low", 3'd7, 16'h0500);
  endtask

  task automatic testUnused();
    for (int i = 0; i < 5; i++) readCheck("R3 unused", 3'(i), 16'h0000);
  endtask

  // defaults: high 8192, release 7552; low 1280, release 1920
  task automatic testOver();
    applySample(16'd8192); checkFlags("R4 equal", 1'b0, 1'b0);
    applySample(16'd8193); checkFlags("R4 above R8", 1'b1, 1'b0);
    applySample(16'd8192); checkFlags("R6 at limit", 1'b1, 1'b0);
    applySample(16'd7552); checkFlags("R6 at release", 1'b1, 1'b0);
    applySample(16'd7551); checkFlags("R6 below release", 1'b0, 1'b0);
  endtask

  task automatic testUnder();
    applySample(16'd1280); checkFlags("R5 equal", 1'b0, 1'b0);
    applySample(16'd1279); checkFlags("R5 below R8", 1'b0, 1'b1);
    applySample(16'd1920); checkFlags("R7 at release", 1'b0, 1'b1);
    applySample(16'd1921); checkFlags("R7 above release", 1'b0, 1'b0);
  endtask

  task automatic testHystMask();
    writeReg(3'd5, 16'hFFAB);
    readCheck("R2 masked", 3'd5, 16'h000B);
    writeReg(3'd5, 16'h0005);
  endtask

  task automatic testNoEval();
    applySample(16'd9000); checkFlags("R11 setup", 1'b1, 1'b0);
    writeReg(3'd6, 16'h7000);
    repeat (3) @(negedge clk);
    checkFlags("R11 after write", 1'b1, 1'b0);
    readCheck("R11 high readback", 3'd6, 16'h7000);
    applySample(16'd0); checkFlags("R11 next sample", 1'b0, 1'b1);
  endtask

  task automatic testSigned();
    writeReg(3'd5, 16'h0000);
    writeReg(3'd6, 16'hFF00);
    writeReg(3'd7, 16'hFE00);
    applySample(16'h0000); checkFlags("R9 zero above negative high", 1'b1, 1'b0);
    applySample(16'hFD00); checkFlags("R9 below negative low", 1'b0, 1'b1);
    applySample(16'hFE00); checkFlags("R9 hyst0 hold", 1'b0, 1'b1);
    applySample(16'hFE01); checkFlags("R9 hyst0 release", 1'b0, 1'b0);
  endtask

  task automatic testNoWrap();
    writeReg(3'd5, 16'h000F);
    writeReg(3'd6, 16'h8000);
    writeReg(3'd7, 16'h7FFF);
    applySample(16'h8001); checkFlags("R10 set both", 1'b1, 1'b1);
    applySample(16'h8000); checkFlags("R10 over no wrap", 1'b1, 1'b1);
    applySample(16'h7FFF); checkFlags("R10 under no wrap", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnused();
    testHystMask();
    testOver();
    testUnder();
    testNoEval();
    testSigned();
    testNoWrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule